// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block takes one group of interrupt request lines and turns them into pending-request bits for an interrupt controller. Each line can be set to edge or level sensing through its own bit in a trigger-mode register. An edge-sensed line latches a request when a rising transition is seen, and keeps it until the controller acknowledges that line. A level-sensed line reports a request for as long as its input stays high, and an acknowledge leaves it alone.

Inputs go through a synchronizer before detection. The controller acknowledges one line at a time with a one-hot strobe. It can also pulse an initialization clear, which empties the pending bits and the stored previous levels but keeps the trigger modes. Software reads and writes the trigger-mode register through a byte-wide port. A fixed, parameterised writable-bits mask stops certain lines from ever being switched to level sensing.

Top module: `irq_req_latch`

## Requirements
- R1: Reset (`rst` high at a clock edge) clears every trigger-mode bit to 0, which is edge sensing, and clears every pending bit.
- R2: A clock edge with `mode_wr_i` high stores `mode_wdata_i & MODE_WMASK` into the trigger-mode register, and this value shows on `mode_rdata_o` after that edge. With the default mask 8'hF8, bits 0 to 2 always read 0. In the register, bit value 1 selects level sensing and bit value 0 selects edge sensing.
- R3: On an edge-sensed line, a low-to-high change on `irq_i[n]` sets `pend_o[n]` on the third clock edge after the change. The path is two synchronizer flops and then the latch.
- R4: An edge-sensed pending bit stays set after its input drops. After an acknowledge, holding the input high does not set the bit again; only a new rising edge does.
- R5: On a level-sensed line, `pend_o[n]` follows the synchronized input. It rises three edges after the input goes high and falls three edges after the input goes low.
- R6: `ack_i` is a one-hot-or-zero strobe that lasts one clock. Acknowledging an edge-sensed line clears its pending bit at that edge. Acknowledging a level-sensed line whose input is high leaves its bit set.
- R7: If a new rising edge is detected on a line in the same cycle that the line is acknowledged, the pending bit stays set.
- R8: An `init_i` pulse clears all pending bits and all previous-level records at the next edge and leaves the trigger-mode register unchanged. As a result, an edge-sensed line whose input is held high becomes pending again one edge later.
- R9: An acknowledge of one line leaves the pending bits of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | LINES | Raw asynchronous request lines |
| ack_i | input | LINES | One-hot acknowledge strobe from the controller |
| init_i | input | 1 | Initialization clear of pending bits and previous levels |
| mode_wr_i | input | 1 | Write strobe for the trigger-mode register |
| mode_wdata_i | input | LINES | Write data for the trigger-mode register |
| mode_rdata_o | output | LINES | Current trigger-mode register contents |
| pend_o | output | LINES | Pending request bits |

## Verification
Each line keeps two bits of hidden state: the pending bit and the previous level. If the previous level is stored wrongly, it shows up in one of two ways. An edge line may latch a second request while its input is held high after an acknowledge. Or an edge may be missed after initialization. Either way the wrong pending bit appears on `pend_o` within one edge of the cycle in which the synchronized level reaches the latch. A trigger-mode bit that is wrong shows at once on `mode_rdata_o`, and it also shows as an acknowledge that clears a bit it should have kept, or the reverse, one edge after the strobe.

// File: rtl/irql_pkg.sv
package irql_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic pend;
        logic prev;
    } lane_state_t;

    typedef struct packed {
        logic       smp;
        logic       ack;
        logic       init;
        trig_mode_e mode;
    } lane_in_t;

    localparam lane_state_t LANE_IDLE = '{pend: 1'b0, prev: 1'b0};

    // Next state of one request line. Init beats everything; in edge mode a
    // fresh rising edge beats a coincident acknowledge.
    function automatic lane_state_t lane_next(lane_state_t cur, lane_in_t in);
        lane_state_t nxt;
        nxt.prev = in.smp;
        if (in.init) begin
            nxt = LANE_IDLE;
        end else if (in.mode == TRIG_LEVEL) begin
            nxt.pend = in.smp;
        end else if (in.smp && !cur.prev) begin
            nxt.pend = 1'b1;
        end else if (in.ack) begin
            nxt.pend = 1'b0;
        end else begin
            nxt.pend = cur.pend;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/irql_sync.sv
module irql_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= '0;
            else     stg[g] <= stg[g-1];
        end
    end

    assign q_o = stg[LAST];

endmodule

// File: rtl/irql_mode_reg.sv
module irql_mode_reg #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] WMASK = 8'hF8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] mode_o
);
    logic [WIDTH-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst)       mode_q <= '0;
        else if (wr_i) mode_q <= wdata_i & WMASK;
    end

    assign mode_o = mode_q;

    // R2
    wr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (mode_o == ($past(wdata_i) & WMASK)));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(mode_o));

endmodule

// File: rtl/irql_lane.sv
module irql_lane
    import irql_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_i,
    input  logic       ack_i,
    input  logic       init_i,
    input  trig_mode_e mode_i,
    output logic       pend_o
);
    lane_state_t st_q;
    lane_in_t    lin;

    always_comb begin
        lin.smp  = smp_i;
        lin.ack  = ack_i;
        lin.init = init_i;
        lin.mode = mode_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LANE_IDLE;
        else     st_q <= lane_next(st_q, lin);
    end

    assign pend_o = st_q.pend;

    // R3
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_i && mode_i == TRIG_EDGE && smp_i && !st_q.prev) |=> pend_o);

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_i && mode_i == TRIG_EDGE && pend_o && !ack_i) |=> pend_o);

    // R6
    lvl_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_i && mode_i == TRIG_LEVEL && smp_i && ack_i) |=> pend_o);

    // R8
    init_clr_chk: assert property (@(posedge clk) disable iff (rst)
        init_i |=> (!pend_o && !st_q.prev));

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irql_pkg::*;
#(
    parameter int               LINES       = 8,
    parameter logic [LINES-1:0] MODE_WMASK  = 8'hF8,
    parameter int               SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_i,
    input  logic [LINES-1:0] ack_i,
    input  logic             init_i,
    input  logic             mode_wr_i,
    input  logic [LINES-1:0] mode_wdata_i,
    output logic [LINES-1:0] mode_rdata_o,
    output logic [LINES-1:0] pend_o
);
    logic [LINES-1:0] irq_s;
    logic [LINES-1:0] mode_q;

    irql_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (irq_i),
        .q_o (irq_s)
    );

    irql_mode_reg #(
        .WIDTH (LINES),
        .WMASK (MODE_WMASK)
    ) u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (mode_wr_i),
        .wdata_i (mode_wdata_i),
        .mode_o  (mode_q)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_lane
        irql_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .smp_i  (irq_s[g]),
            .ack_i  (ack_i[g]),
            .init_i (init_i),
            .mode_i (trig_mode_e'(mode_q[g])),
            .pend_o (pend_o[g])
        );
    end

    assign mode_rdata_o = mode_q;

    // R6
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_i));

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (pend_o == '0 && mode_rdata_o == '0));

endmodule

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq = '0;
    logic [7:0] ack = '0;
    logic       init = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pend;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [7:0] pend;
        logic [7:0] mode;
        string      req;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    irq_req_latch u_dut (
        .clk          (clk),
        .rst          (rst),
        .irq_i        (irq),
        .ack_i        (ack),
        .init_i       (init),
        .mode_wr_i    (wr),
        .mode_wdata_i (wdata),
        .mode_rdata_o (rdata),
        .pend_o       (pend)
    );

    // Monitor: compare scheduled expectations away from the clock edge
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                checks++;
                if (pend !== q[i].pend || rdata !== q[i].mode) begin
                    failures++;
                    $display("FAIL %s cyc=%0d pend=%h mode=%h expected pend=%h mode=%h",
                             q[i].req, cyc, pend, rdata, q[i].pend, q[i].mode);
                end
                q.delete(i);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_in(int d, logic [7:0] p, logic [7:0] m, string r);
        exp_t e;
        e.at = cyc + d; e.pend = p; e.mode = m; e.req = r;
        q.push_back(e);
    endtask

    task automatic write_mode(logic [7:0] v);
        wr = 1'b1; wdata = v;
        step();
        wr = 1'b0;
    endtask

    task automatic pulse_ack(logic [7:0] v);
        ack = v;
        step();
        ack = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired, run hung");
            summary();
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        expect_in(0, 8'h00, 8'h00, "R1 reset state");
        step(2);

        // R2: masked writes
        write_mode(8'hFF);
        expect_in(0, 8'h00, 8'hF8, "R2 mask FF");
        step();
        write_mode(8'h0F);
        expect_in(0, 8'h00, 8'h08, "R2 mask 0F");
        step();
        write_mode(8'h30);
        expect_in(0, 8'h00, 8'h30, "R2 lines 4,5 level");
        step();

        // R3: edge on line 0, three-edge latency
        irq = 8'h01;
        expect_in(2, 8'h00, 8'h30, "R3 not before third edge");
        expect_in(3, 8'h01, 8'h30, "R3 edge latched");
        step(4);

        // R4: stays after input drops
        irq = 8'h00;
        expect_in(4, 8'h01, 8'h30, "R4 held after drop");
        step(4);

        // R6: ack clears edge line
        pulse_ack(8'h01);
        expect_in(0, 8'h00, 8'h30, "R6 ack clears edge");
        step();

        // R5: level line 4
        irq = 8'h10;
        expect_in(3, 8'h10, 8'h30, "R5 level high");
        step(4);
        pulse_ack(8'h10);
        expect_in(0, 8'h10, 8'h30, "R6 ack keeps level");
        irq = 8'h00;
        expect_in(2, 8'h10, 8'h30, "R5 level still synced high");
        expect_in(3, 8'h00, 8'h30, "R5 level low clears");
        step(4);

        // R4: held high does not retrigger after ack
        irq = 8'h02;
        expect_in(3, 8'h02, 8'h30, "R3 edge line 1");
        step(4);
        pulse_ack(8'h02);
        expect_in(0, 8'h00, 8'h30, "R6 ack line 1");
        expect_in(3, 8'h00, 8'h30, "R4 no retrigger while high");
        step(4);
        irq = 8'h00;
        step(4);

        // R7: new edge coinciding with ack
        irq = 8'h04;
        step(3);
        expect_in(0, 8'h04, 8'h30, "R7 setup pending");
        irq = 8'h00;
        step(4);
        irq = 8'h04;
        step(2);
        ack = 8'h04;
        step();
        ack = '0;
        expect_in(0, 8'h04, 8'h30, "R7 edge beats ack");
        step();
        pulse_ack(8'h04);
        expect_in(0, 8'h00, 8'h30, "R6 ack line 2");
        irq = 8'h00;
        step(4);

        // R9: ack of one line leaves others
        irq = 8'h09;
        expect_in(3, 8'h09, 8'h30, "R3 two edge lines");
        step(4);
        irq = 8'h00;
        pulse_ack(8'h01);
        expect_in(0, 8'h08, 8'h30, "R9 other line kept");
        step();
        pulse_ack(8'h08);
        expect_in(0, 8'h00, 8'h30, "R6 ack line 3");
        step(4);

        // R8: init clears pending and previous levels, keeps mode
        irq = 8'h60;
        expect_in(3, 8'h60, 8'h30, "R5 level+edge high");
        step(4);
        init = 1'b1;
        step();
        init = 1'b0;
        expect_in(0, 8'h00, 8'h30, "R8 init clears, mode kept");
        expect_in(1, 8'h60, 8'h30, "R8 prev cleared, re-latched");
        step(3);

        // R1: reset clears mode and pending
        rst = 1'b1;
        step();
        expect_in(0, 8'h00, 8'h00, "R1 reset clears all");
        step();
        rst = 1'b0;
        irq = 8'h00;
        step(4);

        done = 1'b1;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard left %0d unchecked items, expected 0", q.size());
        end
        summary();
    end

endmodule